// File: doc/BRIEF.md
# Glitch-free two-input clock multiplexer

This block picks one of two free-running, mutually asynchronous clocks and passes it to a single clock output. The switch never produces a runt pulse or a glitch. Each input clock owns a lane. A lane consists of an enable synchronizer clocked on the falling edge of that lane's clock, a gate that ANDs the clock with the lane enable, and a watchdog that counts on the same clock. The two gated clocks are ORed to form the output.

When the select line changes, the outgoing lane drops its enable after a short synchronizer delay, which parks the output low. The incoming lane sees that the other enable has gone. It then raises its own enable through its synchronizer, and the output restarts on the next rising edge of the new clock. If the outgoing clock has stopped, it can never drop its own enable. In that case the incoming lane's watchdog clears the stale enable asynchronously, so the switch still completes. If the incoming clock is absent, the output simply rests low until that clock starts.

Top module: `glitchfree_clk_mux`

## Requirements
- R1: With `sel` = 0 the output reproduces `clk0`, and with `sel` = 1 it reproduces `clk1`. Once settled, the output has one rising edge per rising edge of the selected clock, and its high time equals that clock's high time.
- R2: After `sel` changes, the output keeps following the old clock for two or three of its falling edges (counted as output falling edges) and then stays low. A lane enable rises only while `sel` selects that lane.
- R3: After the old clock is gated off, the output stays low across two or three falling edges of the new clock. It then restarts on a rising edge of the new clock.
- R4: Every output high or low pulse lasts at least half the period of the faster input. Every output rising edge coincides with a rising edge of an input clock. The two lane enables are never high together.
- R5: R2, R3 and R4 hold when `clk1` runs ten times slower and ten times faster than `clk0`.
- R6: Switching to a stopped clock releases the old clock as in R2. The output then stays low for as long as the new clock is absent. Once the new clock starts, the output resumes after two or three of its falling edges.
- R7: Switching away from a clock stopped either low or high completes without a glitch. The output restarts between `WDOG_LIMIT` and `WDOG_LIMIT`+4 periods of the new clock after `sel` changes.
- R8: `rst` (active high) is sampled on each clock's falling edge and clears that lane's enable. The output stays low and has no rising edge while `rst` is held. After `rst` is released, the selected clock is admitted after two or three of its falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Input clock chosen when `sel` is 0 |
| clk1 | input | 1 | Input clock chosen when `sel` is 1 |
| rst | input | 1 | Active-high reset, sampled on each lane's falling clock edge |
| sel | input | 1 | Asynchronous select: 0 picks `clk0`, 1 picks `clk1` |
| clk_out | output | 1 | Multiplexed, glitch-free output clock |

## Verification
The assertions assume three things about the inputs. First, `sel` changes no more often than once per 250 periods of the slower clock. Second, the two clocks differ in frequency by no more than a factor of ten. Third, `rst` is first asserted while both clocks are running, because an enable is cleared only by an edge of its own clock or by the other lane's watchdog. The stimulus holds reset from time zero with both clocks toggling. It moves `sel` only a fraction of a nanosecond after a `clk0` edge. It waits 250 periods of the slower clock after each switch. It offsets `clk1` so that the edges of the two clocks never share a timestamp.

// File: rtl/cmux_pkg.sv
`timescale 1ns/1ps
package cmux_pkg;
  localparam int LANES        = 2;
  localparam int DEF_SYNC     = 2;
  localparam int DEF_WDOG     = 64;

  typedef logic [LANES-1:0] lane_vec_t;

  // index of the lane that competes with lane i
  function automatic int other_lane(input int i);
    return LANES - 1 - i;
  endfunction
endpackage

// File: rtl/cmux_sync_chain.sv
`timescale 1ns/1ps
// Falling-edge enable synchronizer for one lane. The async clear lets the
// opposite lane drop this enable when this lane's clock has stopped.
module cmux_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      stg <= '0;
    end else if (rst) begin
      stg <= '0;
    end else begin
      stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmux_wdog.sv
`timescale 1ns/1ps
// Counts falling edges of the lane clock while the lane waits for its turn;
// after LIMIT of them it raises a registered kill for the other lane.
module cmux_wdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic kill
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(negedge clk) begin
    if (rst || !waiting) begin
      cnt  <= '0;
      kill <= 1'b0;
    end else if (cnt == CW'(LIMIT - 1)) begin
      kill <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmux_clk_gate.sv
`timescale 1ns/1ps
// Enable changes only while the clock is low, so the AND cannot chop a pulse.
module cmux_clk_gate (
  input  logic clk_i,
  input  logic en,
  output logic clk_o
);
  assign clk_o = clk_i & en;
endmodule

// File: rtl/glitchfree_clk_mux.sv
`timescale 1ns/1ps
module glitchfree_clk_mux
  import cmux_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC,
  parameter int WDOG_LIMIT  = DEF_WDOG
) (
  input  logic clk0,
  input  logic clk1,
  input  logic rst,
  input  logic sel,
  output logic clk_out
);
  lane_vec_t src_clk;
  lane_vec_t lane_want;
  lane_vec_t lane_req;
  lane_vec_t lane_en;
  lane_vec_t lane_kill;
  lane_vec_t gated;

  assign src_clk   = {clk1, clk0};
  assign lane_want = {sel, ~sel};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int OTH = other_lane(g);

    // a lane may only request once the competing enable is gone
    assign lane_req[g] = lane_want[g] & ~lane_en[OTH];

    cmux_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (src_clk[g]),
      .rst (rst),
      .clr (lane_kill[OTH]),
      .d   (lane_req[g]),
      .q   (lane_en[g])
    );

    cmux_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk     (src_clk[g]),
      .rst     (rst),
      .waiting (lane_want[g] & ~lane_en[g]),
      .kill    (lane_kill[g])
    );

    cmux_clk_gate u_gate (
      .clk_i (src_clk[g]),
      .en    (lane_en[g]),
      .clk_o (gated[g])
    );
  end

  assign clk_out = |gated;
endmodule

// File: rtl/glitchfree_clk_mux_chk.sv
`timescale 1ns/1ps
module glitchfree_clk_mux_chk (
  input logic       clk0,
  input logic       clk1,
  input logic       rst,
  input logic       sel,
  input logic       clk_out,
  input logic [1:0] lane_en
);
  // R4
  excl_on_clk0_chk: assert property (@(negedge clk0) disable iff (rst)
    lane_en[0] |-> !lane_en[1]);

  // R4
  excl_on_clk1_chk: assert property (@(negedge clk1) disable iff (rst)
    lane_en[1] |-> !lane_en[0]);

  // R2
  lane0_rise_sel_chk: assert property (@(negedge clk0) disable iff (rst)
    $rose(lane_en[0]) |-> !sel);

  // R2
  lane1_rise_sel_chk: assert property (@(negedge clk1) disable iff (rst)
    $rose(lane_en[1]) |-> sel);

  // R3
  parked_low_chk: assert property (@(negedge clk0) disable iff (rst)
    (!lane_en[0] && !lane_en[1]) |-> !clk_out);

  // R8
  rst_clears_lane0_chk: assert property (@(negedge clk0)
    rst |=> !lane_en[0]);

  // R8
  rst_clears_lane1_chk: assert property (@(negedge clk1)
    rst |=> !lane_en[1]);
endmodule

bind glitchfree_clk_mux glitchfree_clk_mux_chk u_chk (
  .clk0    (clk0),
  .clk1    (clk1),
  .rst     (rst),
  .sel     (sel),
  .clk_out (clk_out),
  .lane_en (lane_en)
);

// File: tb/glitchfree_clk_mux_tb.sv
`timescale 1ns/1ps
module glitchfree_clk_mux_tb;
  localparam int WDOG = 64;

  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic rst  = 1'b1;
  logic sel  = 1'b0;
  logic clk_out;

  real half0 = 10.0;
  real half1 = 13.0;
  bit  run1  = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  glitchfree_clk_mux #(.SYNC_STAGES(2), .WDOG_LIMIT(WDOG)) u_dut (
    .clk0    (clk0),
    .clk1    (clk1),
    .rst     (rst),
    .sel     (sel),
    .clk_out (clk_out)
  );

  initial forever begin
    #(half0);
    clk0 = ~clk0;
  end

  initial begin
    #0.3;
    forever begin
      #(half1);
      if (run1) clk1 = ~clk1;
    end
  end

  // ---------------- monitors ----------------
  bit  mon_on = 1'b0;
  real tr0 = -1.0, tr1 = -1.0, t_rise_out = -1.0, t_fall_out = -1.0;
  real last_high = 0.0, t_first_rise = 0.0;
  int  negc0 = 0, negc1 = 0, rc0 = 0, rc1 = 0, rco = 0;
  int  runt = 0, misalign = 0;
  bit  armed = 1'b0, got_rise = 1'b0, new_idx = 1'b0;
  int  fall_cnt = 0, snap_neg = 0, hold_cnt = 0;

  function automatic real minhalf();
    return (half0 < half1) ? half0 : half1;
  endfunction

  function automatic real maxhalf();
    return (half0 > half1) ? half0 : half1;
  endfunction

  always @(posedge clk0) begin tr0 = $realtime; rc0++; end
  always @(posedge clk1) begin tr1 = $realtime; rc1++; end
  always @(negedge clk0) negc0++;
  always @(negedge clk1) negc1++;

  always @(negedge clk_out) if (mon_on) begin
    t_fall_out = $realtime;
    if (t_rise_out >= 0.0) begin
      last_high = t_fall_out - t_rise_out;
      if (last_high < minhalf() - 0.01) runt++;
    end
    if (armed && !got_rise) begin
      fall_cnt++;
      #0.05;
      snap_neg = new_idx ? negc1 : negc0;
    end
  end

  always @(posedge clk_out) if (mon_on) begin
    t_rise_out = $realtime;
    rco++;
    if (t_fall_out >= 0.0 && (t_rise_out - t_fall_out) < minhalf() - 0.01) runt++;
    #0.05;
    if (tr0 != t_rise_out && tr1 != t_rise_out) begin
      misalign++;
    end else if (armed && !got_rise &&
                 ((new_idx && tr1 == t_rise_out) || (!new_idx && tr0 == t_rise_out))) begin
      got_rise     = 1'b1;
      t_first_rise = t_rise_out;
      hold_cnt     = (new_idx ? negc1 : negc0) - snap_neg;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input real v, input real lo, input real hi,
                           input string req, input string what);
    n_chk++;
    if (v < lo || v > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f..%0.3f", req, what, v, lo, hi);
    end
  endtask

  task automatic arm(input bit idx);
    fall_cnt = 0;
    got_rise = 1'b0;
    new_idx  = idx;
    runt     = 0;
    misalign = 0;
    snap_neg = idx ? negc1 : negc0;
    armed    = 1'b1;
  endtask

  task automatic wait_rise(input int limit_ns);
    for (int k = 0; k < limit_ns / 10 && !got_rise; k++) #10;
    armed = 1'b0;
  endtask

  task automatic settle();
    #(500.0 * maxhalf());
  endtask

  task automatic glitch_checks(input string req);
    check(runt == 0, req, "R4 pulses below half the faster period", runt, 0);
    check(misalign == 0, req, "R4 output rises off any input rise", misalign, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_start();
    int c;
    #100;
    mon_on = 1'b1;
    c = rco;
    repeat (10) @(posedge clk0);
    #0.41;
    check(rco == c, "R8", "output rises while reset held", rco - c, 0);
    check(clk_out == 1'b0, "R8", "output level in reset", clk_out, 0);
    @(posedge clk0); #0.41;
    arm(1'b0);
    rst = 1'b0;
    wait_rise(2000);
    check(got_rise, "R8", "output started after reset", got_rise, 1);
    check_rng(hold_cnt, 2, 3, "R8", "clk0 falls before admission");
    settle();
    glitch_checks("R8");
  endtask

  task automatic t_steady(input bit idx);
    int a, b;
    real hs;
    hs = idx ? half1 : half0;
    @(posedge clk0); #0.41;
    a = rco;
    b = idx ? rc1 : rc0;
    #(40.0 * hs);
    check((rco - a) == ((idx ? rc1 : rc0) - b), "R1", "output rises vs source rises",
          rco - a, (idx ? rc1 : rc0) - b);
    check(last_high > hs - 0.01 && last_high < hs + 0.01, "R1", "output high time",
          last_high, hs);
  endtask

  task automatic do_switch(input bit to, input string rq, input int rel_lo, input int rel_hi,
                           input bit chk_hold, input bit chk_lat);
    real t_sel, lat;
    @(posedge clk0); #0.41;
    arm(to);
    t_sel = $realtime;
    sel = to;
    wait_rise(200000);
    check(got_rise, rq, "R3 output restarted on new clock", got_rise, 1);
    check_rng(fall_cnt, rel_lo, rel_hi, rq, "R2 old-clock output falls");
    if (chk_hold) check_rng(hold_cnt, 2, 3, rq, "R3 new-clock falls while parked");
    if (chk_lat) begin
      lat = (t_first_rise - t_sel) / (2.0 * (to ? half1 : half0));
      check_rng(lat, WDOG, WDOG + 4, rq, "R7 restart latency in periods");
    end
    settle();
    glitch_checks(rq);
  endtask

  task automatic t_absent_new();
    @(negedge clk1);
    run1 = 1'b0;
    #200;
    @(posedge clk0); #0.41;
    arm(1'b1);
    sel = 1'b1;
    #6000;
    check(!got_rise, "R6", "output restarted with new clock absent", got_rise, 0);
    check(clk_out == 1'b0, "R6", "output level while new clock absent", clk_out, 0);
    check_rng(fall_cnt, 2, 3, "R6", "old-clock output falls");
    run1 = 1'b1;
    wait_rise(20000);
    check(got_rise, "R6", "output restarted once clock returned", got_rise, 1);
    check_rng(hold_cnt, 2, 3, "R6", "new-clock falls before restart");
    settle();
    glitch_checks("R6");
  endtask

  task automatic t_absent_old(input bit stop_high);
    if (stop_high) @(posedge clk1);
    else @(negedge clk1);
    run1 = 1'b0;
    #200;
    if (stop_high) do_switch(1'b0, "R7", 1, 1, 1'b1, 1'b1);
    else do_switch(1'b0, "R7", 0, 0, 1'b0, 1'b1);
    run1 = 1'b1;
    settle();
    do_switch(1'b1, "R7", 2, 3, 1'b1, 1'b0);
  endtask

  task automatic t_reset_mid();
    int c;
    @(posedge clk0); #0.41;
    rst = 1'b1;
    repeat (3) @(posedge clk0);
    #0.41;
    c = rco;
    repeat (10) @(posedge clk0);
    #0.41;
    check(rco == c, "R8", "output rises while reset held mid-run", rco - c, 0);
    check(clk_out == 1'b0, "R8", "output level in mid-run reset", clk_out, 0);
    @(posedge clk0); #0.41;
    arm(1'b1);
    rst = 1'b0;
    wait_rise(2000);
    check(got_rise, "R8", "clk1 admitted after reset", got_rise, 1);
    check_rng(hold_cnt, 2, 3, "R8", "clk1 falls before admission");
    settle();
    glitch_checks("R8");
  endtask

  initial begin
    t_reset_start();
    t_steady(1'b0);
    do_switch(1'b1, "R2", 2, 3, 1'b1, 1'b0);
    t_steady(1'b1);
    do_switch(1'b0, "R3", 2, 3, 1'b1, 1'b0);
    half1 = 100.0;
    settle();
    do_switch(1'b1, "R5", 2, 3, 1'b1, 1'b0);
    t_steady(1'b1);
    do_switch(1'b0, "R5", 2, 3, 1'b1, 1'b0);
    half1 = 1.0;
    settle();
    do_switch(1'b1, "R5", 2, 3, 1'b1, 1'b0);
    t_steady(1'b1);
    do_switch(1'b0, "R5", 2, 3, 1'b1, 1'b0);
    half1 = 13.0;
    settle();
    t_absent_new();
    t_absent_old(1'b0);
    t_absent_old(1'b1);
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule